// File: doc/BRIEF.md
# Three-Channel Power Sequencing Controller

This block decides when each of three power channels is enabled and when it is told to shut down. Channels A and B are regulated outputs that each follow their own power-on request. Channel C is an unregulated output. One configuration bit chooses whether C is requested at all times or whenever A or B is requested. Every channel waits out a selectable turn-on delay before its enable rises, which starts the soft start ramp. It also waits out a selectable turn-off delay before its enable falls, and a one-cycle shutdown pulse marks that fall. All delays are counted in pulses of a shared millisecond tick input.

The regulated channels each have a software restart strobe. The strobe drops the channel at once. After a selectable restart delay the channel comes back, as long as its request is still present. A per-channel link selector can make a channel treat its request as withdrawn when an external fault-link input is raised or when a chosen other channel shuts down. This chains shutdowns between outputs. The ramp generators, the regulation loops and the register bus sit outside this block. All configuration arrives as static inputs.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, every enable and every shutdown output is low.
- R2: A channel's enable rises once its request has been high for the number of tick pulses set by its turn-on code (0: none, 1: 50, 2: 250, 3: 1000). The turn-on code field for channel A is bits [1:0], for B bits [3:2] and for C bits [5:4]. Enable never rises while the request is low.
- R3: After a request is withdrawn, the enable stays high for the number of tick pulses set by the turn-off code, which uses the same code values and field layout as R2. The enable then falls, and the shutdown output is high for exactly that one cycle.
- R4: A request withdrawn before its turn-on delay ends cancels the turn-on. The enable does not rise and no shutdown pulse occurs.
- R5: A request that returns during a turn-off delay keeps the channel enabled, with no shutdown pulse.
- R6: With the follow bit at 0, channel C is requested at all times. With the follow bit at 1, channel C is requested while request A or request B is high.
- R7: Restart strobe bit 0 acts on channel A and bit 1 on channel B. A strobe drops the enable in the next cycle, with a shutdown pulse if the channel was enabled. After the restart delay code (0: none, 1: 500, 2: 1000, 3: 2000 ticks) the enable rises again with no turn-on delay if the request is high; otherwise the channel stays off.
- R8: A strobe that arrives while the channel is off, waiting to turn on, or already in its restart delay starts a fresh full restart delay.
- R9: Each channel has a 2-bit link source (A in bits [1:0], B in [3:2], C in [5:4]). Code 0 means no link and code 1 means the fault-link input. Codes 2 and 3 pick the two other channels in ascending order: for A, B then C; for B, A then C; for C, A then B. When the source fires, the channel behaves as if its request were withdrawn, and it stays off until its own request goes low.
- R10: A restart strobe takes priority over any other transition in the same cycle, including the expiry of a turn-off delay.
- R11: Delay counters advance only in cycles where the millisecond tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| pwr_req_a_i | input | 1 | Power-on request, channel A |
| pwr_req_b_i | input | 1 | Power-on request, channel B |
| sw_restart_i | input | 2 | Restart strobes; bit 0 channel A, bit 1 channel B |
| fault_link_i | input | 1 | External fault-link input |
| cfg_on_dly_i | input | 6 | Turn-on delay codes, 2 bits per channel |
| cfg_off_dly_i | input | 6 | Turn-off delay codes, 2 bits per channel |
| cfg_rst_dly_i | input | 2 | Restart delay code shared by A and B |
| cfg_c_follow_i | input | 1 | 1: C follows A or B; 0: C always requested |
| cfg_link_src_i | input | 6 | Link source codes, 2 bits per channel |
| chan_en_o | output | 3 | Enable per channel (bit 0 A, 1 B, 2 C) |
| chan_shdn_o | output | 3 | One-cycle shutdown pulse per channel |

## Verification
A restart strobe and the expiry of a turn-off delay can land in the same cycle. To provoke this, the bench sets a zero turn-off code and drops the request of channel A. One cycle later it raises the request again together with the strobe. At that point the turn-off delay has just expired, and without the strobe the returning request would keep the channel on. The scoreboard expects exactly one shutdown pulse in the tick slot of the drop, followed by a re-enable a full restart delay later. Any extra or missing pulse, or a re-enable at the wrong tick count, is reported as a mismatch.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int NUM_CH  = 3;
    localparam int NUM_REG = 2;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ON_WAIT,
        ST_ON,
        ST_OFF_WAIT,
        ST_RESTART
    } seq_state_e;

endpackage

// File: rtl/pwr_seq_link.sv
module pwr_seq_link
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_req_i,
    input  logic [NUM_CH-1:0] shdn_i,
    input  logic              fault_i,
    input  logic [2*NUM_CH-1:0] src_i,
    output logic [NUM_CH-1:0] eff_req_o
);

    logic [NUM_CH-1:0] fire;
    logic [NUM_CH-1:0] latch_d, latch_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_src
        localparam int OTH0 = (ch == 0) ? 1 : 0;
        localparam int OTH1 = (ch == NUM_CH - 1) ? NUM_CH - 2 : NUM_CH - 1;
        logic [1:0] sel;
        assign sel = src_i[2*ch +: 2];
        always_comb begin
            case (sel)
                2'd1:    fire[ch] = fault_i;
                2'd2:    fire[ch] = shdn_i[OTH0];
                2'd3:    fire[ch] = shdn_i[OTH1];
                default: fire[ch] = 1'b0;
            endcase
        end

        // R9: once the source fires, the request stays masked while the source is unchanged
        assert_link_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (fire[ch] && raw_req_i[ch] && sel != 2'd0)
            |=> (!eff_req_o[ch] || !raw_req_i[ch] || !$stable(src_i[2*ch +: 2])));
    end

    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            latch_d[ch]   = (src_i[2*ch +: 2] != 2'd0) && raw_req_i[ch] && (latch_q[ch] || fire[ch]);
            eff_req_o[ch] = raw_req_i[ch] && !(latch_q[ch] || fire[ch]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

endmodule

// File: rtl/pwr_seq_chan.sv
module pwr_seq_chan
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int DLY1  = 50,
    parameter int DLY2  = 250,
    parameter int DLY3  = 1000,
    parameter int RDLY1 = 500,
    parameter int RDLY2 = 1000,
    parameter int RDLY3 = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       req_i,
    input  logic       restart_i,
    input  logic [1:0] on_code_i,
    input  logic [1:0] off_code_i,
    input  logic [1:0] rst_code_i,
    output logic       en_o,
    output logic       shdn_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             shdn;
    } chan_regs_t;

    chan_regs_t d, q;

    function automatic logic [CNT_W-1:0] pick(input logic [1:0] c, input int v1, input int v2, input int v3);
        case (c)
            2'd1:    return CNT_W'(v1);
            2'd2:    return CNT_W'(v2);
            2'd3:    return CNT_W'(v3);
            default: return '0;
        endcase
    endfunction

    logic [CNT_W-1:0] on_ld, off_ld, rst_ld, cnt_step;
    logic             expired;

    assign on_ld    = pick(on_code_i,  DLY1,  DLY2,  DLY3);
    assign off_ld   = pick(off_code_i, DLY1,  DLY2,  DLY3);
    assign rst_ld   = pick(rst_code_i, RDLY1, RDLY2, RDLY3);
    assign expired  = (q.cnt == '0);
    assign cnt_step = tick_i ? q.cnt - 1'b1 : q.cnt;

    always_comb begin
        d      = q;
        d.shdn = 1'b0;
        if (restart_i) begin
            d.state = ST_RESTART;
            d.cnt   = rst_ld;
            d.en    = 1'b0;
            d.shdn  = q.en;
        end else begin
            case (q.state)
                ST_OFF: begin
                    if (req_i) begin
                        d.state = ST_ON_WAIT;
                        d.cnt   = on_ld;
                    end
                end
                ST_ON_WAIT: begin
                    if (!req_i) begin
                        d.state = ST_OFF;
                    end else if (expired) begin
                        d.state = ST_ON;
                        d.en    = 1'b1;
                    end else begin
                        d.cnt = cnt_step;
                    end
                end
                ST_ON: begin
                    if (!req_i) begin
                        d.state = ST_OFF_WAIT;
                        d.cnt   = off_ld;
                    end
                end
                ST_OFF_WAIT: begin
                    if (req_i) begin
                        d.state = ST_ON;
                    end else if (expired) begin
                        d.state = ST_OFF;
                        d.en    = 1'b0;
                        d.shdn  = 1'b1;
                    end else begin
                        d.cnt = cnt_step;
                    end
                end
                ST_RESTART: begin
                    if (expired) begin
                        d.state = req_i ? ST_ON : ST_OFF;
                        d.en    = req_i;
                    end else begin
                        d.cnt = cnt_step;
                    end
                end
                default: begin
                    d.state = ST_OFF;
                    d.en    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_OFF;
            q.cnt   <= '0;
            q.en    <= 1'b0;
            q.shdn  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign en_o   = q.en;
    assign shdn_o = q.shdn;

    assert_rise_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.en) |-> $past(req_i));

    assert_shdn_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.shdn |-> (!q.en && $past(q.en)));

    assert_cancel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ON_WAIT && !req_i && !restart_i) |=> (q.state == ST_OFF && !q.shdn && !q.en));

    assert_strobe_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!q.en && q.state == ST_RESTART));

    assert_count_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ON_WAIT && req_i && !restart_i && !tick_i) |=> (q.cnt == $past(q.cnt)));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SEQ_T1_MS = 50,
    parameter int SEQ_T2_MS = 250,
    parameter int SEQ_T3_MS = 1000,
    parameter int RST_T1_MS = 500,
    parameter int RST_T2_MS = 1000,
    parameter int RST_T3_MS = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick_i,
    input  logic       pwr_req_a_i,
    input  logic       pwr_req_b_i,
    input  logic [1:0] sw_restart_i,
    input  logic       fault_link_i,
    input  logic [5:0] cfg_on_dly_i,
    input  logic [5:0] cfg_off_dly_i,
    input  logic [1:0] cfg_rst_dly_i,
    input  logic       cfg_c_follow_i,
    input  logic [5:0] cfg_link_src_i,
    output logic [2:0] chan_en_o,
    output logic [2:0] chan_shdn_o
);

    localparam int MAX_SEQ = (SEQ_T3_MS > SEQ_T2_MS) ? SEQ_T3_MS : SEQ_T2_MS;
    localparam int MAX_RST = (RST_T3_MS > RST_T2_MS) ? RST_T3_MS : RST_T2_MS;
    localparam int MAX_ALL = (MAX_SEQ > MAX_RST) ? MAX_SEQ : MAX_RST;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    logic [NUM_CH-1:0] raw_req, eff_req;

    always_comb begin
        raw_req[0] = pwr_req_a_i;
        raw_req[1] = pwr_req_b_i;
        raw_req[2] = cfg_c_follow_i ? (pwr_req_a_i | pwr_req_b_i) : 1'b1;
    end

    pwr_seq_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_req_i (raw_req),
        .shdn_i    (chan_shdn_o),
        .fault_i   (fault_link_i),
        .src_i     (cfg_link_src_i),
        .eff_req_o (eff_req)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic strb;
        if (ch < NUM_REG) begin : g_reg
            assign strb = sw_restart_i[ch];
        end else begin : g_unreg
            assign strb = 1'b0;
        end

        pwr_seq_chan #(
            .CNT_W (CNT_W),
            .DLY1  (SEQ_T1_MS),
            .DLY2  (SEQ_T2_MS),
            .DLY3  (SEQ_T3_MS),
            .RDLY1 (RST_T1_MS),
            .RDLY2 (RST_T2_MS),
            .RDLY3 (RST_T3_MS)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (ms_tick_i),
            .req_i      (eff_req[ch]),
            .restart_i  (strb),
            .on_code_i  (cfg_on_dly_i[2*ch +: 2]),
            .off_code_i (cfg_off_dly_i[2*ch +: 2]),
            .rst_code_i (cfg_rst_dly_i),
            .en_o       (chan_en_o[ch]),
            .shdn_o     (chan_shdn_o[ch])
        );
    end

    // R6: in always-on mode with no link, C never receives a shutdown from a request drop
    assert_c_always_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_c_follow_i && $past(!cfg_c_follow_i) && cfg_link_src_i[5:4] == 2'd0
         && $past(cfg_link_src_i[5:4] == 2'd0) && $past(chan_en_o[2]) && $past(sw_restart_i) == 2'b00)
        |-> chan_en_o[2]);

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;

    localparam int TPER = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       req_a = 1'b0, req_b = 1'b0;
    logic [1:0] strobe = 2'b00;
    logic       fault = 1'b0;
    logic [5:0] on_dly, off_dly, link_src;
    logic [1:0] rst_dly;
    logic       follow;
    logic [2:0] en, shdn;

    int compared = 0;
    int mismatched = 0;
    int tcnt = 0;
    int ph = 0;
    bit mon_on = 0;
    bit done = 0;
    logic [2:0] en_prev = 3'b000;

    typedef struct {
        int    ch;
        int    kind;
        int    stamp;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(TPER/2) clk = ~clk;

    pwr_seq_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ms_tick_i      (tick),
        .pwr_req_a_i    (req_a),
        .pwr_req_b_i    (req_b),
        .sw_restart_i   (strobe),
        .fault_link_i   (fault),
        .cfg_on_dly_i   (on_dly),
        .cfg_off_dly_i  (off_dly),
        .cfg_rst_dly_i  (rst_dly),
        .cfg_c_follow_i (follow),
        .cfg_link_src_i (link_src),
        .chan_en_o      (en),
        .chan_shdn_o    (shdn)
    );

    // tick: high for one cycle out of four
    always @(negedge clk) begin
        ph   = (ph + 1) % 4;
        tick = (ph == 0);
    end
    always @(posedge clk) if (tick) tcnt = tcnt + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int ch, input int kind, input int stamp, input string tag);
        exp_t e;
        e.ch = ch; e.kind = kind; e.stamp = stamp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic observe(input int ch, input int kind);
        exp_t e;
        if (sb.size() == 0) begin
            check(0, $sformatf("unexpected ch%0d kind%0d", ch, kind), tcnt, -1);
        end else begin
            e = sb.pop_front();
            check(e.ch == ch && e.kind == kind && e.stamp == tcnt,
                  $sformatf("%s ch%0d kind%0d (exp ch%0d kind%0d)", e.tag, ch, kind, e.ch, e.kind),
                  tcnt, e.stamp);
        end
    endtask

    // monitor: 0 = enable rise, 1 = shutdown pulse
    always @(negedge clk) begin
        if (mon_on) begin
            for (int ch = 0; ch < 3; ch++) begin
                if (en[ch] && !en_prev[ch]) observe(ch, 0);
                if (shdn[ch]) observe(ch, 1);
            end
        end
        en_prev = en;
    end

    // return at a negedge whose following posedge carries no tick
    task automatic sync();
        do @(posedge clk); while (!tick);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) sync();
    endtask

    task automatic pulse_strobe(input logic [1:0] s);
        strobe = s;
        @(negedge clk);
        strobe = 2'b00;
    endtask

    task automatic drained(input string tag);
        check(sb.size() == 0, {tag, " pending events"}, sb.size(), 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(TPER * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int t;
        on_dly   = {2'd0, 2'd2, 2'd1};
        off_dly  = {2'd3, 2'd0, 2'd1};
        rst_dly  = 2'd1;
        follow   = 1'b1;
        link_src = 6'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(en == 3'b000, "R1 enables after reset", en, 0);
        check(shdn == 3'b000, "R1 shutdowns after reset", shdn, 0);
        mon_on = 1;

        // R2 / R6 follow mode: A on 50, C follows at 0 delay
        sync(); t = tcnt; req_a = 1;
        expect_ev(2, 0, t, "R6 C follows A");
        expect_ev(0, 0, t + 50, "R2 A on 50");
        wait_ticks(60);
        sync(); t = tcnt; req_b = 1;
        expect_ev(1, 0, t + 250, "R2 B on 250");
        wait_ticks(260);
        // R3: A off 50
        sync(); t = tcnt; req_a = 0;
        expect_ev(0, 1, t + 50, "R3 A off 50");
        wait_ticks(20);
        check(en[0] == 1'b1, "R3 A held during off delay", en[0], 1);
        wait_ticks(40);
        // R3 code 0 for B, code 3 for C
        sync(); t = tcnt; req_b = 0;
        expect_ev(1, 1, t, "R3 B off 0");
        expect_ev(2, 1, t + 1000, "R3 C off 1000");
        wait_ticks(1010);
        drained("R3");

        // mute C via external link so it stays out of the next tests
        sync(); link_src = {2'd1, 2'd0, 2'd0}; fault = 1;

        // R4 cancel
        sync(); req_a = 1;
        wait_ticks(20);
        sync(); req_a = 0;
        wait_ticks(60);
        check(en[0] == 1'b0, "R4 cancelled turn-on", en[0], 0);
        drained("R4");

        // R5 re-request during off delay
        sync(); t = tcnt; req_a = 1;
        expect_ev(0, 0, t + 50, "R5 A on");
        wait_ticks(60);
        sync(); req_a = 0;
        wait_ticks(20);
        sync(); req_a = 1;
        wait_ticks(60);
        check(en[0] == 1'b1, "R5 A kept on", en[0], 1);
        drained("R5");

        // R7 restart of A, delay 500
        sync(); t = tcnt; pulse_strobe(2'b01);
        expect_ev(0, 1, t, "R7 A strobe off");
        expect_ev(0, 0, t + 500, "R7 A restart 500");
        wait_ticks(510);

        // R8 reload: B waiting to turn on, strobed twice
        sync(); req_b = 1;
        wait_ticks(100);
        sync(); pulse_strobe(2'b10);
        wait_ticks(200);
        sync(); t = tcnt; pulse_strobe(2'b10);
        expect_ev(1, 0, t + 500, "R8 B reloaded 500");
        wait_ticks(510);
        drained("R8");

        // R7 strobe with request gone: stays off
        sync(); rst_dly = 2'd0;
        sync(); t = tcnt; req_a = 0; pulse_strobe(2'b01);
        expect_ev(0, 1, t, "R7 A strobe no request");
        wait_ticks(5);
        check(en[0] == 1'b0, "R7 A stays off", en[0], 0);

        // R10 strobe in the cycle the zero off delay expires
        sync(); off_dly[1:0] = 2'd0; rst_dly = 2'd1;
        sync(); t = tcnt; req_a = 1;
        expect_ev(0, 0, t + 50, "R10 A on");
        wait_ticks(60);
        sync(); t = tcnt; req_a = 0;
        @(negedge clk); req_a = 1; pulse_strobe(2'b01);
        expect_ev(0, 1, t, "R10 single shutdown");
        expect_ev(0, 0, t + 500, "R10 restart wins");
        wait_ticks(510);
        drained("R10");

        // R9 B linked to A shutdown (code 2 for B = A)
        sync(); off_dly[3:2] = 2'd1; link_src[3:2] = 2'd2;
        sync(); t = tcnt; req_a = 0;
        expect_ev(0, 1, t, "R9 A off");
        expect_ev(1, 1, t + 50, "R9 B linked off");
        wait_ticks(60);
        check(en[1] == 1'b0, "R9 B held off with request high", en[1], 0);
        sync(); req_b = 0;
        wait_ticks(2);
        sync(); t = tcnt; req_b = 1;
        expect_ev(1, 0, t + 250, "R9 B relinks after withdrawal");
        wait_ticks(260);

        // R9 external fault link for A (code 1)
        sync(); fault = 0; link_src[1:0] = 2'd1; link_src[3:2] = 2'd0;
        sync(); t = tcnt; req_a = 1;
        expect_ev(0, 0, t + 50, "R9 A on");
        wait_ticks(60);
        sync(); t = tcnt; fault = 1;
        expect_ev(0, 1, t, "R9 A fault-link off");
        wait_ticks(2);
        sync(); fault = 0;
        wait_ticks(10);
        check(en[0] == 1'b0, "R9 A latched off", en[0], 0);
        sync(); t = tcnt; req_b = 0;
        expect_ev(1, 1, t + 50, "R9 B off");
        wait_ticks(60);
        drained("R9");

        // R6 always-on mode
        sync(); t = tcnt; req_a = 0; link_src = 6'd0; follow = 0;
        expect_ev(2, 0, t, "R6 C always on");
        wait_ticks(5);
        check(en == 3'b100, "R6 only C on", en, 4);
        sync(); t = tcnt; follow = 1; off_dly[5:4] = 2'd1;
        expect_ev(2, 1, t + 50, "R6 C follows idle A/B");
        wait_ticks(60);
        check(en == 3'b000, "R6 all off", en, 0);
        drained("R6");

        summary();
    end

endmodule